// File: doc/BRIEF.md
# SMI Request Aggregation Unit

This block gathers system-management interrupt requests into a single request word. It masks that word with a per-source enable field and drives one SMI line toward the processor. Software programs the unit through a 32-bit configuration write port that has per-byte enables. The port addresses two registers: a control word and a request word. A separate pair of byte-wide power-management ports, command and status, sits on a one-bit I/O decode. A command write is the software trigger: it raises a dedicated request flag when that source is enabled.

The SMI output is a pure function of the stored state. It is high only while the global gate bit is set and at least one enabled source has its request flag up. Because it is formed from registers alone, it follows any write on the clock edge that stores that write.

Top module: `smi_request_hub`

## Requirements
- R1: After reset, the control word, request word, command byte and status byte all read 0, and `smi_o` is low.
- R2: Control bit 0 is the global gate. While it is 0, `smi_o` is low whatever the request and enable fields hold.
- R3: Control bits 24:16 hold the 9-bit per-source enable field. All other control bits except bit 0 always read 0.
- R4: Request bits 24:16 hold one flag per source, written directly by a request-word write. Bits outside 24:16 always read 0. A flag changes only through such a write or through R8.
- R5: `smi_o` equals gate AND (request field AND enable field is non-zero). It reflects a write from the clock edge that stores it.
- R6: A configuration write changes only the byte lanes whose enable bit is set (lane k covers bits 8k+7:8k). The other lanes keep their values.
- R7: A port write at offset 0 stores the command byte. A port read at offset 0 returns the last command byte.
- R8: A command write sets request flag 7 (request bit 23) when enable bit 7 (control bit 23) is 1. When that enable bit is 0, the command write leaves the request word unchanged.
- R9: Offset 1 is a plain status byte. Writing it changes neither the command byte, the request word nor `smi_o`.
- R10: If a request-word write clears bit 23 in the same cycle as a setting command write, the flag ends up set.
- R11: A command write tests the enable value held before the edge. A control write in the same cycle does not affect that decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | Write target: 0 control, 1 request |
| cfg_be | input | 4 | Byte-lane enables for the write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rd_sel | input | 1 | Read select: 0 control, 1 request |
| cfg_rdata | output | 32 | Selected configuration word |
| pm_wr_en | input | 1 | Power-management port write strobe |
| pm_addr | input | 1 | Port offset: 0 command, 1 status (read and write) |
| pm_wdata | input | 8 | Port write data |
| pm_rdata | output | 8 | Byte at the addressed port |
| smi_o | output | 1 | SMI output |

## Verification
The main function is tried with every single-source request against an enable field that alternates between enabled and disabled sources. This separates a correct per-source AND from a shifted or OR-reduced mask. The bench toggles the gate with requests pending, which isolates the gate term from the mask. It exercises partial byte enables that split the enable field across two lanes. Command writes are made with enable bit 7 both set and clear, and are collided with same-cycle request and control writes. These collisions tell apart set-over-clear priority and old-versus-new enable sampling.

// File: rtl/smi_hub_pkg.sv
package smi_hub_pkg;
  localparam int unsigned DEF_CFG_W   = 32;
  localparam int unsigned DEF_SRC_N   = 9;
  localparam int unsigned DEF_SRC_LSB = 16;
  localparam int unsigned DEF_SW_SRC  = 7;
  localparam int unsigned DEF_PORT_W  = 8;
  localparam int unsigned GATE_BIT    = 0;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_REQ  = 1'b1
  } cfg_sel_e;

  typedef enum logic {
    PORT_CMD = 1'b0,
    PORT_STS = 1'b1
  } pm_sel_e;
endpackage

// File: rtl/smi_cfg_regs.sv
module smi_cfg_regs
  import smi_hub_pkg::*;
#(
  parameter int unsigned CFG_W   = DEF_CFG_W,
  parameter int unsigned SRC_N   = DEF_SRC_N,
  parameter int unsigned SRC_LSB = DEF_SRC_LSB,
  parameter int unsigned SW_SRC  = DEF_SW_SRC,
  localparam int unsigned LANES  = CFG_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [LANES-1:0] wr_be,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             sw_trig,
  output logic             gate,
  output logic [SRC_N-1:0] en_field,
  output logic [SRC_N-1:0] req_field,
  output logic [CFG_W-1:0] ctrl_word,
  output logic [CFG_W-1:0] req_word
);
  localparam logic [CFG_W-1:0] FIELD_MASK =
    {{(CFG_W-SRC_N){1'b0}}, {SRC_N{1'b1}}} << SRC_LSB;
  localparam logic [CFG_W-1:0] CTRL_MASK = FIELD_MASK | (CFG_W'(1) << GATE_BIT);
  localparam int unsigned SW_BIT = SRC_LSB + SW_SRC;

  logic [CFG_W-1:0] lane_mask;
  logic [CFG_W-1:0] ctrl_q, ctrl_d;
  logic [CFG_W-1:0] req_q, req_d;
  logic             ctrl_ce, req_ce;
  logic             ctrl_hit, req_hit, sw_hit;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_mask[l*8 +: 8] = {8{wr_be[l]}};
  end

  assign ctrl_hit = wr_en && (wr_sel == SEL_CTRL);
  assign req_hit  = wr_en && (wr_sel == SEL_REQ);
  assign sw_hit   = sw_trig && ctrl_q[SW_BIT];
  assign ctrl_ce  = ctrl_hit;
  assign req_ce   = req_hit || sw_hit;

  always_comb begin
    ctrl_d = ((ctrl_q & ~lane_mask) | (wr_data & lane_mask)) & CTRL_MASK;
    req_d  = req_q;
    if (req_hit) req_d = ((req_q & ~lane_mask) | (wr_data & lane_mask)) & FIELD_MASK;
    if (sw_hit)  req_d[SW_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_ce) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= '0;
    else if (req_ce) req_q <= req_d;
  end

  assign gate      = ctrl_q[GATE_BIT];
  assign en_field  = ctrl_q[SRC_LSB +: SRC_N];
  assign req_field = req_q[SRC_LSB +: SRC_N];
  assign ctrl_word = ctrl_q;
  assign req_word  = req_q;

  // R8: an enabled command write leaves flag 7 set
  assert_sw_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_trig && ctrl_q[SW_BIT]) |=> req_q[SW_BIT]);

  // R4: request word only moves on a request write or trigger
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_hit && !sw_trig) |=> $stable(req_q));

  // R6: gate lane untouched when lane 0 is not enabled
  assert_lane_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hit && !wr_be[0]) |=> (ctrl_q[GATE_BIT] == $past(ctrl_q[GATE_BIT])));
endmodule

// File: rtl/smi_pm_ports.sv
module smi_pm_ports
  import smi_hub_pkg::*;
#(
  parameter int unsigned PORT_W = DEF_PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] rdata,
  output logic              cmd_strobe
);
  logic [PORT_W-1:0] cmd_q, sts_q;
  logic              cmd_ce, sts_ce;

  assign cmd_ce = wr_en && (addr == PORT_CMD);
  assign sts_ce = wr_en && (addr == PORT_STS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_ce) cmd_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_ce) sts_q <= wdata;
  end

  assign rdata      = (addr == PORT_STS) ? sts_q : cmd_q;
  assign cmd_strobe = cmd_ce;

  // R9: status writes never touch the command byte
  assert_sts_plain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == PORT_STS) |=> $stable(cmd_q));
endmodule

// File: rtl/smi_out_gen.sv
module smi_out_gen #(
  parameter int unsigned SRC_N = smi_hub_pkg::DEF_SRC_N
) (
  input  logic             gate,
  input  logic [SRC_N-1:0] en_field,
  input  logic [SRC_N-1:0] req_field,
  output logic             smi
);
  logic [SRC_N-1:0] live;
  assign live = en_field & req_field;
  assign smi  = gate && (|live);
endmodule

// File: rtl/smi_request_hub.sv
module smi_request_hub
  import smi_hub_pkg::*;
#(
  parameter int unsigned CFG_W   = DEF_CFG_W,
  parameter int unsigned SRC_N   = DEF_SRC_N,
  parameter int unsigned SRC_LSB = DEF_SRC_LSB,
  parameter int unsigned SW_SRC  = DEF_SW_SRC,
  parameter int unsigned PORT_W  = DEF_PORT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic                 cfg_wr_sel,
  input  logic [CFG_W/8-1:0]   cfg_be,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic                 cfg_rd_sel,
  output logic [CFG_W-1:0]     cfg_rdata,
  input  logic                 pm_wr_en,
  input  logic                 pm_addr,
  input  logic [PORT_W-1:0]    pm_wdata,
  output logic [PORT_W-1:0]    pm_rdata,
  output logic                 smi_o
);
  logic             gate;
  logic [SRC_N-1:0] en_field, req_field;
  logic [CFG_W-1:0] ctrl_word, req_word;
  logic             cmd_strobe;

  smi_pm_ports #(.PORT_W(PORT_W)) u_ports (
    .clk(clk), .rst_n(rst_n), .wr_en(pm_wr_en), .addr(pm_addr),
    .wdata(pm_wdata), .rdata(pm_rdata), .cmd_strobe(cmd_strobe)
  );

  smi_cfg_regs #(.CFG_W(CFG_W), .SRC_N(SRC_N), .SRC_LSB(SRC_LSB), .SW_SRC(SW_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel),
    .wr_be(cfg_be), .wr_data(cfg_wdata), .sw_trig(cmd_strobe),
    .gate(gate), .en_field(en_field), .req_field(req_field),
    .ctrl_word(ctrl_word), .req_word(req_word)
  );

  smi_out_gen #(.SRC_N(SRC_N)) u_out (
    .gate(gate), .en_field(en_field), .req_field(req_field), .smi(smi_o)
  );

  assign cfg_rdata = (cfg_rd_sel == SEL_REQ) ? req_word : ctrl_word;

  // R5: the SMI line only rises after a write of some kind
  assert_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_o) |-> $past(cfg_wr_en || pm_wr_en));

  // R2: a low gate in the control word keeps the line low
  assert_gate_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[GATE_BIT] |-> !smi_o);
endmodule

// File: tb/smi_request_hub_tb_top.sv
module smi_request_hub_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_wr_sel = 1'b0, cfg_rd_sel = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        pm_wr_en = 1'b0, pm_addr = 1'b0;
  logic [7:0]  pm_wdata = '0, pm_rdata;
  logic        smi_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_ctrl = '0, m_req = '0;
  logic [7:0]  m_cmd = '0, m_sts = '0;

  always #5 clk = ~clk;

  smi_request_hub dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rd_sel(cfg_rd_sel),
    .cfg_rdata(cfg_rdata), .pm_wr_en(pm_wr_en), .pm_addr(pm_addr),
    .pm_wdata(pm_wdata), .pm_rdata(pm_rdata), .smi_o(smi_o)
  );

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic exp_smi();
    return m_ctrl[0] && ((m_ctrl[24:16] & m_req[24:16]) != 9'd0);
  endfunction

  task automatic check_all(string tag);
    cmp(tag, "smi_o", {31'd0, smi_o}, {31'd0, exp_smi()});
    cfg_rd_sel = 1'b0; #1 cmp(tag, "control", cfg_rdata, m_ctrl);
    cfg_rd_sel = 1'b1; #1 cmp(tag, "request", cfg_rdata, m_req);
    pm_addr = 1'b0;    #1 cmp(tag, "command", {24'd0, pm_rdata}, {24'd0, m_cmd});
    pm_addr = 1'b1;    #1 cmp(tag, "status", {24'd0, pm_rdata}, {24'd0, m_sts});
  endtask

  // one clock of stimulus; model advances from the old state only
  task automatic step(input logic cw, input logic csel, input logic [3:0] be,
                      input logic [31:0] cd, input logic pw, input logic pa,
                      input logic [7:0] pd, input string tag);
    logic [31:0] wm, n_ctrl, n_req;
    @(negedge clk);
    cfg_wr_en = cw; cfg_wr_sel = csel; cfg_be = be; cfg_wdata = cd;
    pm_wr_en = pw; pm_addr = pa; pm_wdata = pd;
    wm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    n_ctrl = m_ctrl; n_req = m_req;
    if (cw && !csel) n_ctrl = ((m_ctrl & ~wm) | (cd & wm)) & 32'h01FF_0001;
    if (cw && csel)  n_req  = ((m_req & ~wm) | (cd & wm)) & 32'h01FF_0000;
    if (pw && !pa && m_ctrl[23]) n_req[23] = 1'b1;
    if (pw && !pa) m_cmd = pd;
    if (pw && pa)  m_sts = pd;
    m_ctrl = n_ctrl; m_req = n_req;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0; pm_wr_en = 1'b0;
    check_all(tag);
  endtask

  task automatic wctrl(logic [3:0] be, logic [31:0] d, string tag);
    step(1'b1, 1'b0, be, d, 1'b0, 1'b0, 8'h00, tag);
  endtask
  task automatic wreq(logic [3:0] be, logic [31:0] d, string tag);
    step(1'b1, 1'b1, be, d, 1'b0, 1'b0, 8'h00, tag);
  endtask
  task automatic wport(logic a, logic [7:0] d, string tag);
    step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, a, d, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    wctrl(4'b0001, 32'h0000_0001, "R2");            // gate only, nothing enabled
    wreq(4'b1111, 32'hFFFF_FFFF, "R4");             // outside bits read 0
    wctrl(4'b1111, 32'hFFFF_FFFF, "R3");            // all enables, smi high (R5)
    wctrl(4'b0001, 32'h0000_0000, "R2");            // gate off with requests pending
    wctrl(4'b0100, 32'h00AA_0001, "R6");            // lane 2 only: en = 1AA, gate stays 0
    wctrl(4'b0001, 32'h0000_0001, "R5");
    wreq(4'b1100, 32'h0000_0000, "R4");             // clear all flags
    for (int i = 0; i < 9; i++) wreq(4'b1111, 32'h1 << (16 + i), "R5");
    wreq(4'b1111, 32'h0, "R4");

    wport(1'b0, 8'h5A, "R8");                        // enable 7 set: flag 7 raised
    wport(1'b0, 8'h11, "R7");
    wreq(4'b0100, 32'h0, "R4");
    wctrl(4'b0100, 32'h002A_0000, "R6");            // enable 7 cleared
    wport(1'b0, 8'h33, "R8");                        // no flag
    wctrl(4'b0100, 32'h0080_0000, "R6");            // enable 7 set again
    wport(1'b1, 8'hC3, "R9");                        // status: no side effect
    wport(1'b1, 8'h3C, "R9");

    wport(1'b0, 8'h01, "R8");
    step(1'b1, 1'b1, 4'b0100, 32'h0, 1'b1, 1'b0, 8'h02, "R10");  // clear vs set
    wreq(4'b1111, 32'h0, "R4");
    step(1'b1, 1'b0, 4'b0100, 32'h0000_0000, 1'b1, 1'b0, 8'h03, "R11"); // old enable=1
    wreq(4'b1111, 32'h0, "R4");
    step(1'b1, 1'b0, 4'b0100, 32'h0080_0000, 1'b1, 1'b0, 8'h04, "R11"); // old enable=0

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule